// File: doc/BRIEF.md
# Quad SPI Flash Read Controller

This block sits between an instruction-fetch path and an external serial NOR flash. A requester hands over a 24-bit byte address, a burst length and a flag that picks the single-line path. The controller runs the flash pins and streams the bytes back one per strobe. On the first request after reset it wakes the flash. Its normal path is a four-line read whose mode byte keeps the flash in continuous mode, so later frames skip the command byte.

The serial clock runs at half the system clock and stays low while chip select is high. After a burst, chip select is left low. A following request whose address continues the previous one, of the same kind, just resumes clocking. Any other request closes the frame and opens a new one. When a single-line command must be sent while continuous mode is active, a mode-bit reset frame goes out first.

Top module: `qspi_xip_ctrl`

## Requirements
- R1: During and right after reset, chip select is high (`flash_cs_n`=1), the serial clock is low, all four output enables are 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The first request after reset is preceded by a chip-select frame of its own that carries only command 0xAB, shifted out MSB first on line 0.
- R3: The serial clock is high for exactly one system cycle at a time and low whenever chip select is high. Driven line values and enables change only while the clock falls, and never in the cycle in which it rises.
- R4: A four-line read without continuous mode sends 0xEB serially on line 0. It then sends address bits 23..0 followed by mode byte 0xA5 on four lines, two clocks per byte, high nibble first, with bit 7 on line 3, bit 6 on line 2, bit 5 on line 1 and bit 4 on line 0.
- R5: After the mode byte exactly 8 clocks pass with all enables 0. Each later clock captures one nibble, and the first nibble is the byte's high nibble, taken as {line3, line2, line1, line0}.
- R6: Once a 0xA5 mode byte has been sent, the next four-line frame starts directly with the address and sends no command byte.
- R7: A request of the same kind whose address equals the previous burst's last address plus one, arriving while chip select is still low, continues clocking data without a new frame or any address.
- R8: A single-line request (`req_single`=1) sends 0x03 and a 24-bit address MSB first on line 0, then captures each byte MSB first from line 1 over 8 clocks. If continuous mode is active, it is first preceded by a frame of 8 clocks that drives all four lines high.
- R9: A request returns `req_len`+1 bytes in address order, each on a one-cycle `rsp_valid` pulse that is never back to back. `req_ready` is 0 while a burst is being fetched.
- R10: The controller's enables are 0 on every line the flash may drive: during dummy clocks, during data clocks and whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_single | input | 1 | 1 selects the single-line read path |
| req_addr | input | 24 | Byte address of the burst |
| req_len | input | LEN_W | Burst length minus one |
| rsp_valid | output | 1 | One-cycle strobe per returned byte |
| rsp_data | output | 8 | Returned byte |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_io_out | output | 4 | Values driven onto data lines 3..0 |
| flash_io_oe | output | 4 | Per-line output enable |
| flash_io_in | input | 4 | Sampled data lines 3..0 |

## Verification
The bench drives a behavioural flash with its own continuous-mode state and compares every returned byte with a data function of the address. A controller that skipped the mode-bit reset would have its 0x03 command taken as address nibbles, and the single-line bytes would come back wrong. A wrong dummy count or a wrong nibble order shifts every captured byte. Frame and command counters catch an extra frame on a contiguous request, or a command byte resent in continuous mode. Each cycle the bench also flags any line driven by both sides at once.

// File: rtl/qspi_xip_pkg.sv
package qspi_xip_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DUMMY = 3'd3,
        ST_DATA  = 3'd4,
        ST_HOLD  = 3'd5,
        ST_RST   = 3'd6,
        ST_END   = 3'd7
    } ctrl_state_e;

    localparam logic [7:0] OP_WAKE  = 8'hAB;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_QREAD = 8'hEB;
    localparam logic [7:0] MODE_KEEP = 8'hA5;

endpackage

// File: rtl/qspi_lane_drive.sv
module qspi_lane_drive #(
    parameter int LANES = 4
) (
    input  logic             drive_en,
    input  logic             wide,
    input  logic             force_high,
    input  logic [LANES-1:0] nib,
    output logic [LANES-1:0] io_out,
    output logic [LANES-1:0] io_oe
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_l0
            assign io_out[i] = drive_en & (force_high | (wide ? nib[i] : nib[LANES-1]));
            assign io_oe[i]  = drive_en;
        end else begin : g_ln
            assign io_out[i] = drive_en & (force_high | (wide & nib[i]));
            assign io_oe[i]  = drive_en & (wide | force_high);
        end
    end
endmodule

// File: rtl/qspi_rx_gather.sv
module qspi_rx_gather (
    input  logic       wide,
    input  logic [6:0] rx_in,
    input  logic [3:0] io_in,
    output logic [7:0] rx_out
);
    always_comb begin
        if (wide) rx_out = {rx_in[3:0], io_in};
        else      rx_out = {rx_in, io_in[1]};
    end
endmodule

// File: rtl/qspi_xip_ctrl.sv
module qspi_xip_ctrl
    import qspi_xip_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 8,
    parameter int DUMMY_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_single,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              flash_cs_n,
    output logic              flash_sck,
    output logic [3:0]        flash_io_out,
    output logic [3:0]        flash_io_oe,
    input  logic [3:0]        flash_io_in
);
    localparam int SH_W  = ADDR_W + 8;
    localparam int CNT_W = $clog2(ADDR_W + DUMMY_CLKS + 1);
    localparam logic [CNT_W-1:0] SLOTS_SER  = CNT_W'(8);
    localparam logic [CNT_W-1:0] SLOTS_QUAD = CNT_W'(2);
    localparam logic [CNT_W-1:0] SLOTS_QHDR = CNT_W'(SH_W / 4);
    localparam logic [CNT_W-1:0] SLOTS_SADR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] SLOTS_DUM  = CNT_W'(DUMMY_CLKS);

    typedef struct packed {
        ctrl_state_e       st;
        logic              ph;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-1:0]   sh;
        logic [6:0]        rx;
        logic              wide;
        logic              awake;
        logic              cont;
        logic              wake;
        logic              pend;
        logic              single;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic              rsp_v;
        logic [7:0]        rsp_d;
    } ctrl_regs_t;

    ctrl_regs_t q, d;
    logic       start_go;
    logic [7:0] rx_next;
    logic       drive_en;

    qspi_rx_gather u_gather (
        .wide   (q.wide),
        .rx_in  (q.rx),
        .io_in  (flash_io_in),
        .rx_out (rx_next)
    );

    assign drive_en = (q.st == ST_CMD) || (q.st == ST_ADDR) || (q.st == ST_RST);

    qspi_lane_drive #(.LANES(4)) u_drive (
        .drive_en   (drive_en),
        .wide       (q.wide),
        .force_high (q.st == ST_RST),
        .nib        (q.sh[SH_W-1 -: 4]),
        .io_out     (flash_io_out),
        .io_oe      (flash_io_oe)
    );

    always_comb begin
        d        = q;
        d.rsp_v  = 1'b0;
        start_go = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr   = req_addr;
                    d.left   = req_len;
                    d.single = req_single;
                    start_go = 1'b1;
                end
            end
            ST_END: begin
                if (q.pend) start_go = 1'b1;
                else        d.st = ST_IDLE;
            end
            ST_HOLD: begin
                if (req_valid) begin
                    if (req_single == q.single && req_addr == q.addr) begin
                        d.left = req_len;
                        d.st   = ST_DATA;
                        d.cnt  = q.single ? SLOTS_SER : SLOTS_QUAD;
                    end else begin
                        d.addr   = req_addr;
                        d.left   = req_len;
                        d.single = req_single;
                        d.pend   = 1'b1;
                        d.st     = ST_END;
                    end
                end
            end
            default: begin
                d.ph = ~q.ph;
                if (!q.ph) begin
                    if (q.st == ST_DATA) begin
                        d.rx = rx_next[6:0];
                        if (q.cnt == CNT_W'(1)) begin
                            d.rsp_v = 1'b1;
                            d.rsp_d = rx_next;
                        end
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                    d.sh  = q.wide ? (q.sh << 4) : (q.sh << 1);
                    if (q.cnt == CNT_W'(1)) begin
                        case (q.st)
                            ST_CMD: begin
                                if (q.wake) begin
                                    d.wake  = 1'b0;
                                    d.awake = 1'b1;
                                    d.st    = ST_END;
                                end else if (q.single) begin
                                    d.st  = ST_ADDR;
                                    d.sh  = {q.addr, 8'h00};
                                    d.cnt = SLOTS_SADR;
                                end else begin
                                    d.st   = ST_ADDR;
                                    d.sh   = {q.addr, MODE_KEEP};
                                    d.cnt  = SLOTS_QHDR;
                                    d.wide = 1'b1;
                                end
                            end
                            ST_ADDR: begin
                                if (q.single) begin
                                    d.st  = ST_DATA;
                                    d.cnt = SLOTS_SER;
                                end else begin
                                    d.cont = 1'b1;
                                    d.st   = ST_DUMMY;
                                    d.cnt  = SLOTS_DUM;
                                end
                            end
                            ST_DUMMY: begin
                                d.st  = ST_DATA;
                                d.cnt = SLOTS_QUAD;
                            end
                            ST_RST: begin
                                d.cont = 1'b0;
                                d.st   = ST_END;
                            end
                            ST_DATA: begin
                                d.addr = q.addr + 1'b1;
                                if (q.left == '0) begin
                                    d.st = ST_HOLD;
                                end else begin
                                    d.left = q.left - 1'b1;
                                    d.cnt  = q.single ? SLOTS_SER : SLOTS_QUAD;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        endcase

        if (start_go) begin
            d.pend = 1'b0;
            d.ph   = 1'b0;
            d.cnt  = SLOTS_SER;
            d.wide = 1'b0;
            if (!q.awake) begin
                d.st   = ST_CMD;
                d.sh   = {OP_WAKE, {ADDR_W{1'b0}}};
                d.wake = 1'b1;
                d.pend = 1'b1;
            end else if (d.single && q.cont) begin
                d.st   = ST_RST;
                d.wide = 1'b1;
                d.pend = 1'b1;
            end else if (d.single) begin
                d.st = ST_CMD;
                d.sh = {OP_READ, {ADDR_W{1'b0}}};
            end else if (q.cont) begin
                d.st   = ST_ADDR;
                d.sh   = {d.addr, MODE_KEEP};
                d.cnt  = SLOTS_QHDR;
                d.wide = 1'b1;
            end else begin
                d.st = ST_CMD;
                d.sh = {OP_QREAD, {ADDR_W{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE) || (q.st == ST_HOLD);
    assign flash_cs_n = (q.st == ST_IDLE) || (q.st == ST_END);
    assign flash_sck  = q.ph;
    assign rsp_valid  = q.rsp_v;
    assign rsp_data   = q.rsp_d;

endmodule

// File: rtl/qspi_xip_ctrl_chk.sv
module qspi_xip_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       flash_cs_n,
    input logic       flash_sck,
    input logic [3:0] flash_io_out,
    input logic [3:0] flash_io_oe
);
    // R1 and R10: quiet lines and low clock while deselected
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> (flash_io_oe == 4'h0 && !flash_sck));

    // R3: clock high for one cycle only
    p_sck_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sck |=> !flash_sck);

    // R3: lines settled across the rising clock
    p_rise_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_sck) |-> ($stable(flash_io_out) && $stable(flash_io_oe)));

    // R10: controller released the lines while a byte is captured
    p_rx_tristate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (flash_io_oe == 4'h0));

    // R9: byte strobes never back to back
    p_rsp_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: no new request taken mid-burst
    p_rsp_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

bind qspi_xip_ctrl qspi_xip_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .flash_cs_n   (flash_cs_n),
    .flash_sck    (flash_sck),
    .flash_io_out (flash_io_out),
    .flash_io_oe  (flash_io_oe)
);

// File: tb/qspi_xip_ctrl_bench.sv
module qspi_xip_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int F_NONE = 0, F_CMD = 1, F_AS = 2, F_AQ = 3, F_DUM = 4, F_DS = 5, F_DQ = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_single = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        cs_n, sck;
    logic [3:0]  io_out, io_oe, io_in;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int exp_q[$];

    // flash model state
    logic [3:0]  f_oe = '0, f_out = '0;
    bit          f_prev_cs = 1'b1, f_prev_sck = 1'b0;
    bit          f_awake = 1'b0, f_cont = 1'b0;
    int          f_st = F_NONE, f_nb = 0, f_rises = 0, f_ones = 0, f_dc = 0, f_pos = 0;
    logic [7:0]  f_sr8 = '0, f_mode = '0;
    logic [31:0] f_sr32 = '0;
    logic [23:0] f_addr = '0;
    int          frames = 0, cmd_cnt = 0, contention = 0;
    logic [7:0]  cmd_log [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < 4; i++) begin : g_pull
        assign io_in[i] = f_oe[i] ? f_out[i] : 1'b1;
    end

    qspi_xip_ctrl u_qspi_xip_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_single(req_single), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .flash_cs_n(cs_n),
        .flash_sck(sck), .flash_io_out(io_out), .flash_io_oe(io_oe),
        .flash_io_in(io_in)
    );

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[22:16], 1'b0} ^ 8'h3C;
    endfunction

    function automatic logic [3:0] lines();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = io_oe[i] ? io_out[i] : 1'b1;
        return v;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural flash, evaluated away from the active edge
    always @(negedge clk) begin
        logic [3:0] ln;
        logic [7:0] b;
        ln = lines();
        if (cs_n) begin
            if (!f_prev_cs && f_rises == 8 && f_ones == 8) f_cont = 1'b0;
            f_oe = '0;
            f_prev_cs = 1'b1;
            f_prev_sck = sck;
        end else begin
            if (f_prev_cs) begin
                frames++;
                f_st = f_cont ? F_AQ : F_CMD;
                f_nb = 0; f_rises = 0; f_ones = 0;
            end
            f_prev_cs = 1'b0;
            if (sck && !f_prev_sck) begin
                f_rises++;
                if (ln[0]) f_ones++;
                case (f_st)
                    F_CMD: begin
                        f_sr8 = {f_sr8[6:0], ln[0]};
                        f_nb++;
                        if (f_nb == 8) begin
                            if (cmd_cnt < 16) cmd_log[cmd_cnt] = f_sr8;
                            cmd_cnt++;
                            f_nb = 0;
                            f_st = F_NONE;
                            if (f_sr8 == 8'hAB) f_awake = 1'b1;
                            if (f_sr8 == 8'hB9) f_awake = 1'b0;
                            if (f_awake && f_sr8 == 8'h03) f_st = F_AS;
                            if (f_awake && f_sr8 == 8'hEB) f_st = F_AQ;
                        end
                    end
                    F_AS: begin
                        f_addr = {f_addr[22:0], ln[0]};
                        f_nb++;
                        if (f_nb == 24) begin f_st = F_DS; f_pos = 0; end
                    end
                    F_AQ: begin
                        f_sr32 = {f_sr32[27:0], ln};
                        f_nb++;
                        if (f_nb == 8) begin
                            f_addr = f_sr32[31:8];
                            f_mode = f_sr32[7:0];
                            f_cont = (f_mode == 8'hA5);
                            f_st = F_DUM;
                            f_dc = 0;
                        end
                    end
                    F_DUM: begin
                        f_dc++;
                        if (f_dc == 8) begin f_st = F_DQ; f_pos = 0; end
                    end
                    default: ;
                endcase
            end else if (!sck && f_prev_sck) begin
                b = fbyte(f_addr);
                if (f_st == F_DS) begin
                    f_oe = 4'b0010;
                    f_out = {2'b00, b[7 - f_pos], 1'b0};
                    f_pos++;
                    if (f_pos == 8) begin f_pos = 0; f_addr = f_addr + 24'd1; end
                end else if (f_st == F_DQ) begin
                    f_oe = 4'b1111;
                    f_out = (f_pos == 0) ? b[7:4] : b[3:0];
                    f_pos = 1 - f_pos;
                    if (f_pos == 0) f_addr = f_addr + 24'd1;
                end
            end
            f_prev_sck = sck;
        end
        if ((io_oe & f_oe) != 4'h0) contention++;
    end

    // reference comparison of the response stream on every clock
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) chk("R9 unexpected byte", rsp_data, 0);
            else begin
                chk("R5/R9 returned byte", rsp_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic issue(input logic [23:0] a, input int len, input logic single);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = 8'(len); req_single = single;
        for (int i = 0; i <= len; i++) exp_q.push_back(int'(fbyte(24'(a + i))));
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", cs_n, 1);
        chk("R1 sck in reset", sck, 0);
        chk("R1 oe in reset", io_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 req_ready after reset", req_ready, 1);

        // first quad burst: wake frame then command frame (R2, R4)
        issue(24'h000100, 3, 1'b0);
        chk("R2 wake command first", cmd_log[0], 8'hAB);
        chk("R4 quad command second", cmd_log[1], 8'hEB);
        chk("R2 wake in own frame", frames, 2);
        chk("R4 mode byte", f_mode, 8'hA5);

        // contiguous quad continuation (R7)
        issue(24'h000104, 1, 1'b0);
        chk("R7 no new frame", frames, 2);

        // jump: continuous-mode frame without command (R6)
        issue(24'h012345, 2, 1'b0);
        chk("R6 new frame opened", frames, 3);
        chk("R6 no command byte", cmd_cnt, 2);

        // single-line read after continuous mode (R8)
        issue(24'h00ABCD, 2, 1'b1);
        chk("R8 reset plus read frames", frames, 5);
        chk("R8 read command", cmd_log[2], 8'h03);
        chk("R8 continuous mode left", f_cont, 0);

        // contiguous single-line continuation (R7)
        issue(24'h00ABD0, 0, 1'b1);
        chk("R7 single no new frame", frames, 5);

        // quad read needs a command again (R4, R6)
        issue(24'h000200, 5, 1'b0);
        chk("R4 quad command reissued", cmd_log[3], 8'hEB);
        chk("R6 command count", cmd_cnt, 4);

        chk("R9 all bytes returned", exp_q.size(), 0);
        chk("R10 no line contention", contention, 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule